// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers six interrupt sources into one shared interrupt line. The sources are periodic tick, alarm match, update end, wake-up, kickstart and RAM-clear done. Each source has a sticky flag that an external one-cycle event pulse sets. Each source also has an enable bit. The block drives the line low while at least one source has both its flag and its enable set. Otherwise it releases the line. The open-drain pin is modelled as a drive-low enable. The block has no high drive.

Software uses a small register port with four addresses. Two addresses hold the enables. One address is the main status register. Reading it returns the summary bit and the three standard flags, and that read clears those three flags. The fourth address holds the three extended flags, and writing a zero to an extended flag's bit clears that flag. Several devices can share the interrupt line. The line stays low until software has cleared every flag that is both active and enabled.

Top module: `irq_aggr`

## Requirements
- R1: After reset, all flags and enables are 0, `irq_oe_o` and `irqf_o` are 0, and every register reads 0.
- R2: An event pulse on `evt_i[k]` sets flag k at the next clock edge, whatever the value of its enable. Bit order is 0 periodic, 1 alarm, 2 update, 3 wake, 4 kick, 5 ram-clear.
- R3: `irqf_o` and `irq_oe_o` equal the OR over all six sources of (flag AND enable). When no enabled flag is set, the line is released (`irq_oe_o` = 0).
- R4: The status register (sel 1) reads the summary bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3:0 always read 0.
- R5: The control register (sel 0) holds the periodic enable at bit 6, the alarm enable at bit 5 and the update enable at bit 4. It is written with `wr_i`, and all its other bits read 0.
- R6: The extended flag register (sel 2) and the extended enable register (sel 3) both place ram-clear at bit 2, wake at bit 1 and kick at bit 0. Their other bits read 0.
- R7: A read of the status register returns the value before the read. It then clears the periodic, alarm and update flags at that clock edge. The extended flags are left unchanged.
- R8: An event that arrives in the same cycle as a clearing read or write sets its flag. The event wins over the clear.
- R9: Writing the extended flag register clears each extended flag whose written bit is 0. A written 1 leaves that flag as it is.
- R10: While the line is driven, it stays driven until every flag that is both active and enabled has been cleared.
- R11: A write to the status register, and a read of any register other than the status register, change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 6 | One-cycle source events |
| sel_i | input | 2 | Register select: 0 control, 1 status, 2 extended flags, 3 extended enables |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irqf_o | output | 1 | Summary interrupt bit |
| irq_oe_o | output | 1 | Drive-low enable for the open-drain interrupt pin |

## Verification
The bench builds the block with its default widths: six sources and an 8-bit data path. At that size every one of the 64 enable patterns can be combined with every one of the 64 flag patterns. This makes 4096 pairs. For each pair the bench computes the expected summary bit, status value and extended flag value arithmetically, then clears the flags and checks that the line is released. Directed cases add the rest:
- an event arriving together with a clearing access;
- partial clears of the extended flags;
- a line held by one source after the others are cleared;
- accesses that must have no effect.

// File: rtl/irq_aggr_pkg.sv
`timescale 1ns/1ps
package irq_aggr_pkg;
  localparam int NSRC     = 6;
  localparam int DW       = 8;
  localparam int AW       = 2;
  localparam int NSTD     = 3;
  localparam int IRQF_BIT = 7;

  typedef enum logic [AW-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_XFLG = 2'd2,
    REG_XEN  = 2'd3
  } reg_sel_e;

  // bit position of a source in its flag/enable register
  function automatic int bit_pos(input int src);
    case (src)
      0: return 6;
      1: return 5;
      2: return 4;
      3: return 1;
      4: return 0;
      default: return 2;
    endcase
  endfunction

  function automatic bit is_std(input int src);
    return src < NSTD;
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
`timescale 1ns/1ps
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over clear so a coincident event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_en_regs.sv
`timescale 1ns/1ps
module irq_en_regs
  import irq_aggr_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] sel_i,
  input  logic [W-1:0]  wdata_i,
  output logic [N-1:0]  en_o
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[W-1], wdata_i[3]};

  for (genvar s = 0; s < N; s++) begin : g_en
    localparam reg_sel_e HOME = is_std(s) ? REG_CTRL : REG_XEN;
    localparam int       BP   = bit_pos(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        en_o[s] <= 1'b0;
      else if (wr_i && sel_i == AW'(HOME)) en_o[s] <= wdata_i[BP];
    end
  end
endmodule

// File: rtl/irq_combine.sv
`timescale 1ns/1ps
module irq_combine #(
  parameter int N = 6
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irqf_o
);
  assign irqf_o = |(flag_i & en_i);
endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux
  import irq_aggr_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = DW
) (
  input  logic [AW-1:0] sel_i,
  input  logic [N-1:0]  flag_i,
  input  logic [N-1:0]  en_i,
  input  logic          irqf_i,
  output logic [W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (sel_i)
      AW'(REG_CTRL): begin
        for (int s = 0; s < N; s++)
          if (is_std(s)) rdata_o[bit_pos(s)] = en_i[s];
      end
      AW'(REG_STAT): begin
        rdata_o[IRQF_BIT] = irqf_i;
        for (int s = 0; s < N; s++)
          if (is_std(s)) rdata_o[bit_pos(s)] = flag_i[s];
      end
      AW'(REG_XFLG): begin
        for (int s = 0; s < N; s++)
          if (!is_std(s)) rdata_o[bit_pos(s)] = flag_i[s];
      end
      default: begin
        for (int s = 0; s < N; s++)
          if (!is_std(s)) rdata_o[bit_pos(s)] = en_i[s];
      end
    endcase
  end
endmodule

// File: rtl/irq_aggr.sv
`timescale 1ns/1ps
module irq_aggr
  import irq_aggr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [AW-1:0] sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irqf_o,
  output logic          irq_oe_o
);
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] clr;
  logic            stat_rd;
  logic            xflg_wr;

  assign stat_rd = rd_i && (sel_i == AW'(REG_STAT));
  assign xflg_wr = wr_i && (sel_i == AW'(REG_XFLG));

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (is_std(s)) begin : g_std
      assign clr[s] = stat_rd;
    end else begin : g_ext
      assign clr[s] = xflg_wr && !wdata_i[bit_pos(s)];
    end
    irq_flag_cell u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[s]),
      .clr_i  (clr[s]),
      .flag_o (flag_q[s])
    );
  end

  irq_en_regs #(.N(NSRC), .W(DW)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .sel_i   (sel_i),
    .wdata_i (wdata_i),
    .en_o    (en_q)
  );

  irq_combine #(.N(NSRC)) u_comb (
    .flag_i (flag_q),
    .en_i   (en_q),
    .irqf_o (irqf_o)
  );

  // open-drain pin: only ever pulled low
  assign irq_oe_o = irqf_o;

  irq_read_mux #(.N(NSRC), .W(DW)) u_rmux (
    .sel_i   (sel_i),
    .flag_i  (flag_q),
    .en_i    (en_q),
    .irqf_i  (irqf_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/irq_aggr_chk.sv
`timescale 1ns/1ps
module irq_aggr_chk
  import irq_aggr_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] evt_i,
  input logic [AW-1:0]   sel_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic [DW-1:0]   rdata_o,
  input logic            irqf_o,
  input logic            irq_oe_o,
  input logic [NSRC-1:0] flg,
  input logic [NSRC-1:0] en
);
  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flg & $past(evt_i)) == $past(evt_i)));

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == AW'(REG_STAT)) |=> ((flg[2:0] & ~$past(evt_i[2:0])) == 3'b000));

  a_r7_ext_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && sel_i == AW'(REG_STAT)) |=> ((flg[5:3] & $past(flg[5:3])) == $past(flg[5:3])));

  a_r4_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == AW'(REG_STAT)) |-> (rdata_o[3:0] == 4'h0));

  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flg & en) == '0) |-> (!irq_oe_o && !irqf_o));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_oe_o && !rd_i && !wr_i) |=> irq_oe_o);
endmodule

bind irq_aggr irq_aggr_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .sel_i    (sel_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .rdata_o  (rdata_o),
  .irqf_o   (irqf_o),
  .irq_oe_o (irq_oe_o),
  .flg      (flag_q),
  .en       (en_q)
);

// File: tb/irq_aggr_test.sv
`timescale 1ns/1ps
module irq_aggr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt = '0;
  logic [1:0] sel = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irqf;
  logic       irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggr uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .sel_i(sel), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irqf_o(irqf), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0; #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; #1;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0; #1;
  endtask

  // expected register images from the requirement bit layouts (R4, R5, R6)
  function automatic logic [7:0] stat_img(input logic [5:0] f, input logic [5:0] e);
    return {|(f & e), f[0], f[1], f[2], 4'h0};
  endfunction
  function automatic logic [7:0] ext_img(input logic [5:0] v);
    return {5'b0, v[5], v[3], v[4]};
  endfunction
  function automatic logic [7:0] ctl_img(input logic [5:0] v);
    return {1'b0, v[0], v[1], v[2], 4'h0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 oe", {7'b0, irq_oe}, 8'h00);
    chk("R1 irqf", {7'b0, irqf}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d); chk("R1 reg", d, 8'h00);
    end

    // R5 / R6 unused bits read 0
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, d); chk("R5 ctrl", d, 8'h70);
    wr_reg(2'd3, 8'hFF); rd_reg(2'd3, d); chk("R6 xen", d, 8'h07);

    // exhaustive sweep of enables x flags (R2 R3 R4 R6 R7 R9)
    for (int e = 0; e < 64; e++) begin
      wr_reg(2'd0, ctl_img(6'(e)));
      wr_reg(2'd3, ext_img(6'(e)));
      for (int f = 0; f < 64; f++) begin
        pulse(6'(f));
        chk("R3 oe", {7'b0, irq_oe}, {7'b0, |(6'(f) & 6'(e))});
        chk("R3 irqf", {7'b0, irqf}, {7'b0, |(6'(f) & 6'(e))});
        rd_reg(2'd2, d); chk("R2 xflg", d, ext_img(6'(f)));
        rd_reg(2'd1, d); chk("R4 stat", d, stat_img(6'(f), 6'(e)));
        rd_reg(2'd2, d); chk("R7 xflg kept", d, ext_img(6'(f)));
        wr_reg(2'd2, 8'h00);
        chk("R9 released", {7'b0, irq_oe}, 8'h00);
        rd_reg(2'd1, d); chk("R7 stat cleared", d, 8'h00);
      end
    end

    // R8: event coincident with clearing read
    wr_reg(2'd0, 8'h00); wr_reg(2'd3, 8'h00);
    pulse(6'b000001);
    @(negedge clk); sel = 2'd1; rd = 1'b1; evt = 6'b000010;
    @(negedge clk); rd = 1'b0; evt = '0; #1;
    rd_reg(2'd1, d); chk("R8 read vs event", d, 8'h20);
    // R8: event coincident with clearing write
    @(negedge clk); sel = 2'd2; wdata = 8'h00; wr = 1'b1; evt = 6'b001000;
    @(negedge clk); wr = 1'b0; evt = '0; #1;
    rd_reg(2'd2, d); chk("R8 write vs event", d, 8'h02);

    // R9: partial clears
    pulse(6'b110000);
    rd_reg(2'd2, d); chk("R9 all set", d, 8'h07);
    wr_reg(2'd2, 8'hFD); rd_reg(2'd2, d); chk("R9 clear wake", d, 8'h05);
    wr_reg(2'd2, 8'hFF); rd_reg(2'd2, d); chk("R9 ones keep", d, 8'h05);
    wr_reg(2'd2, 8'hFA); rd_reg(2'd2, d); chk("R9 clear rest", d, 8'h00);

    // R10: line held by wake after status read
    wr_reg(2'd0, 8'h40); wr_reg(2'd3, 8'h02);
    pulse(6'b001001);
    chk("R10 asserted", {7'b0, irq_oe}, 8'h01);
    rd_reg(2'd1, d); chk("R10 stat", d, 8'hC0);
    chk("R10 still held", {7'b0, irq_oe}, 8'h01);
    wr_reg(2'd2, 8'h00);
    chk("R10 released", {7'b0, irq_oe}, 8'h00);

    // R11: ignored accesses
    pulse(6'b010111);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd0, d); rd_reg(2'd2, d); rd_reg(2'd3, d);
    rd_reg(2'd2, d); chk("R11 xflg", d, 8'h01);
    rd_reg(2'd1, d); chk("R11 stat", d, 8'hF0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule